// File: doc/BRIEF.md
# Gated ADC Sample Acquisition Controller

This block takes measurements from a free-running pipelined ADC, using a gate that a trigger starts. A rising edge on one selected trigger line opens a gate of programmable length. The block then takes ADC samples at two programmable offsets. The first offset is counted from the gate opening and the second from the gate closing. Both offsets are meant to absorb the converter's pipeline latency, which is typically 18 cycles. The clock is assumed to run at 100 MHz, so one count is 10 ns.

Depending on the selected recording mode, the block stores one of the following:
- a signed baseline-subtracted value (late sample minus early sample);
- the early sample alone;
- the late sample alone;
- both samples;
- every sample between the two capture points.

Each stored value goes into a result FIFO and raises a one-cycle strobe. A host configures the block through a small word-addressed register port and pops results from it one at a time.

Top module: `gated_sample_acq`

## Requirements
- R1: After reset, a read of address 1 returns 0 (bit 16 = 0, FIFO empty), `ovf_flag` and `rec_strobe` are 0, and a read of address 0 returns the parameter `BUS_ID` in bits 7:0. The reset parameter values are: select 0, gate length 100, early offset 18, late offset 18, mode 0.
- R2: A measurement starts only on a 0-to-1 transition of `trig_in[sel]`, where `sel` is the select register. Edges on other lines, edges while a measurement is in progress, and a level held high do not start a measurement. A select value of `TRIG_N` or higher never triggers.
- R3: The clock edge that first sees the trigger high is edge E. The early sample is `adc_data` at edge E+1+D and the late sample is `adc_data` at edge E+1+G+L. Here G is the gate length, D the early offset and L the late offset.
- R4: Mode code 0, and also codes 5, 6 and 7, store one record per measurement: late minus early, as a 15-bit signed value sign-extended to 16 bits.
- R5: Mode code 1 stores only the late sample and mode code 2 stores only the early sample, each zero-extended to 16 bits.
- R6: Mode code 3 stores two records per measurement, the early sample first and then the late sample. This requires D <= G+L.
- R7: Mode code 4 stores every sample from edge E+1+D through edge E+1+G+L in time order, which is G+L-D+1 records.
- R8: A read of address 1 returns bit 16 = 1 and the oldest record in bits 15:0, then removes that record. When the FIFO is empty it returns 0 and removes nothing.
- R9: When the FIFO holds `DEPTH` records, further records are dropped and `ovf_flag` is set and stays set. Any register write empties the FIFO and clears `ovf_flag`.
- R10: `rec_strobe` pulses high for one cycle for each record actually stored, and not for dropped records.
- R11: The write register map is:
  - address 0: trigger select, bits 7:0;
  - address 1: gate length, bits 15:0;
  - address 2: early offset in bits 7:0 and mode in bits 16:14;
  - address 4: late offset, bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 100 MHz nominal |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | TRIG_N | Candidate trigger lines |
| adc_data | input | ADC_W | Free-running ADC sample stream |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| rec_strobe | output | 1 | One pulse per stored record |
| ovf_flag | output | 1 | Sticky FIFO overflow |

## Verification
The hardest state to reach from the ports is a full FIFO while records keep arriving, because each trigger normally yields only one or two records. The bench reaches it by selecting the capture-everything mode with a 600-cycle gate and zero offsets. A single trigger then produces 601 consecutive records. The bench checks that exactly 512 strobes occur, that the overflow flag rises, that the oldest record survives, and that a register write clears both the FIFO and the flag. A retrigger pulse inside an open gate and a held-high trigger after the gate closes cover the rule that later edges are ignored.

// File: rtl/gsa_pkg.sv
package gsa_pkg;
  localparam logic [2:0] MODE_DIFF  = 3'd0;
  localparam logic [2:0] MODE_LATE  = 3'd1;
  localparam logic [2:0] MODE_EARLY = 3'd2;
  localparam logic [2:0] MODE_BOTH  = 3'd3;
  localparam logic [2:0] MODE_ALL   = 3'd4;

  localparam logic [2:0] ADDR_SEL   = 3'd0;
  localparam logic [2:0] ADDR_GATE  = 3'd1;
  localparam logic [2:0] ADDR_CTRL  = 3'd2;
  localparam logic [2:0] ADDR_LATE  = 3'd4;
  localparam logic [2:0] ADDR_POP   = 3'd1;
  localparam logic [2:0] ADDR_ID    = 3'd0;

  typedef enum logic [1:0] {S_IDLE, S_GATE, S_TAIL} seq_state_e;
endpackage

// File: rtl/gsa_trig_edge.sv
module gsa_trig_edge #(
  parameter int TRIG_N = 8,
  parameter int SEL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TRIG_N-1:0] trig_in,
  input  logic [SEL_W-1:0]  sel,
  output logic              edge_o
);
  logic pick;
  logic prev_q;

  always_comb begin
    pick = 1'b0;
    for (int i = 0; i < TRIG_N; i++)
      if (sel == SEL_W'(i)) pick = trig_in[i];
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= pick;
  end

  assign edge_o = pick & ~prev_q;
endmodule

// File: rtl/gsa_gate_seq.sv
module gsa_gate_seq
  import gsa_pkg::*;
#(
  parameter int ADC_W  = 14,
  parameter int GATE_W = 16,
  parameter int DLY_W  = 8,
  parameter int REC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_edge,
  input  logic [GATE_W-1:0] gate_len,
  input  logic [DLY_W-1:0]  early_dly,
  input  logic [DLY_W-1:0]  late_dly,
  input  logic [2:0]        mode,
  input  logic [ADC_W-1:0]  adc,
  output logic              push_o,
  output logic [REC_W-1:0]  push_data_o
);
  localparam int CNT_W = GATE_W + 1;

  seq_state_e         state_q;
  logic [CNT_W-1:0]   t_q, end_t;
  logic [ADC_W-1:0]   early_q, late_q, early_val;
  logic               hit_early, hit_late;
  logic               push_n;
  logic [REC_W-1:0]   data_n;
  logic signed [ADC_W:0] diff;

  assign end_t     = {1'b0, gate_len} + CNT_W'(late_dly);
  assign hit_early = (t_q == CNT_W'(early_dly));
  assign hit_late  = (t_q == end_t);
  assign early_val = hit_early ? adc : early_q;
  assign diff      = $signed({1'b0, adc}) - $signed({1'b0, early_val});

  always_comb begin
    push_n = 1'b0;
    data_n = '0;
    if (state_q == S_GATE) begin
      case (mode)
        MODE_LATE: if (hit_late) begin
          push_n = 1'b1; data_n = REC_W'(adc);
        end
        MODE_EARLY, MODE_BOTH: if (hit_early) begin
          push_n = 1'b1; data_n = REC_W'(adc);
        end
        MODE_ALL: if (t_q >= CNT_W'(early_dly)) begin
          push_n = 1'b1; data_n = REC_W'(adc);
        end
        default: if (hit_late) begin
          push_n = 1'b1; data_n = REC_W'(diff);
        end
      endcase
    end else if (state_q == S_TAIL) begin
      push_n = 1'b1;
      data_n = REC_W'(late_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      t_q         <= '0;
      early_q     <= '0;
      late_q      <= '0;
      push_o      <= 1'b0;
      push_data_o <= '0;
    end else begin
      push_o      <= push_n;
      push_data_o <= data_n;
      case (state_q)
        S_IDLE: if (trig_edge) begin
          state_q <= S_GATE;
          t_q     <= '0;
          early_q <= '0;
        end
        S_GATE: begin
          if (hit_early) early_q <= adc;
          if (hit_late) begin
            late_q  <= adc;
            state_q <= (mode == MODE_BOTH) ? S_TAIL : S_IDLE;
          end else begin
            t_q <= t_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gsa_fifo.sv
module gsa_fifo #(
  parameter int DEPTH = 512,
  parameter int W     = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_data,
  output logic                       empty,
  output logic                       wr_ok,
  output logic                       ovf,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, rd_ok;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign wr_ok   = wr_en & ~full & ~clr;
  assign rd_ok   = rd_en & ~empty & ~clr;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (rd_ok) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + (AW+1)'(wr_ok) - (AW+1)'(rd_ok);
      if (wr_en && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/gated_sample_acq.sv
module gated_sample_acq
  import gsa_pkg::*;
#(
  parameter int          TRIG_N = 8,
  parameter int          ADC_W  = 14,
  parameter int          GATE_W = 16,
  parameter int          DLY_W  = 8,
  parameter int          REC_W  = 16,
  parameter int          DEPTH  = 512,
  parameter logic [7:0]  BUS_ID = 8'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TRIG_N-1:0] trig_in,
  input  logic [ADC_W-1:0]  adc_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              rec_strobe,
  output logic              ovf_flag
);
  localparam int SEL_W = 8;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic [SEL_W-1:0]  sel_q;
  logic [GATE_W-1:0] gate_q;
  logic [DLY_W-1:0]  early_q, late_q;
  logic [2:0]        mode_q;

  logic              trig_edge;
  logic              seq_push;
  logic [REC_W-1:0]  seq_data, head;
  logic              fifo_empty, fifo_wr_ok, fifo_rd;
  logic [CW-1:0]     fifo_count;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      gate_q  <= GATE_W'(100);
      early_q <= DLY_W'(18);
      late_q  <= DLY_W'(18);
      mode_q  <= MODE_DIFF;
    end else if (reg_wr) begin
      case (reg_addr)
        ADDR_SEL:  sel_q  <= reg_wdata[SEL_W-1:0];
        ADDR_GATE: gate_q <= reg_wdata[GATE_W-1:0];
        ADDR_CTRL: begin
          early_q <= reg_wdata[DLY_W-1:0];
          mode_q  <= reg_wdata[16:14];
        end
        ADDR_LATE: late_q <= reg_wdata[DLY_W-1:0];
        default: ;
      endcase
    end
  end

  gsa_trig_edge #(.TRIG_N(TRIG_N), .SEL_W(SEL_W)) u_edge (
    .clk(clk), .rst(rst), .trig_in(trig_in), .sel(sel_q), .edge_o(trig_edge)
  );

  gsa_gate_seq #(.ADC_W(ADC_W), .GATE_W(GATE_W), .DLY_W(DLY_W), .REC_W(REC_W)) u_seq (
    .clk(clk), .rst(rst), .trig_edge(trig_edge), .gate_len(gate_q),
    .early_dly(early_q), .late_dly(late_q), .mode(mode_q), .adc(adc_data),
    .push_o(seq_push), .push_data_o(seq_data)
  );

  assign fifo_rd = reg_rd && (reg_addr == ADDR_POP);

  gsa_fifo #(.DEPTH(DEPTH), .W(REC_W)) u_fifo (
    .clk(clk), .rst(rst), .clr(reg_wr), .wr_en(seq_push), .wr_data(seq_data),
    .rd_en(fifo_rd), .rd_data(head), .empty(fifo_empty), .wr_ok(fifo_wr_ok),
    .ovf(ovf_flag), .count(fifo_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      rec_strobe <= 1'b0;
    end else begin
      rec_strobe <= fifo_wr_ok;
      reg_rdata  <= '0;
      if (reg_rd) begin
        if (reg_addr == ADDR_ID) reg_rdata[7:0] <= BUS_ID;
        else if (reg_addr == ADDR_POP && !fifo_empty && !reg_wr) begin
          reg_rdata[REC_W]     <= 1'b1;
          reg_rdata[REC_W-1:0] <= head;
        end
      end
    end
  end
endmodule

// File: rtl/gated_sample_acq_chk.sv
module gated_sample_acq_chk
  import gsa_pkg::*;
#(
  parameter int GATE_W = 16,
  parameter int DEPTH  = 512
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    reg_wr,
  input logic                    ovf_flag,
  input logic                    rec_strobe,
  input logic                    seq_push,
  input logic [$clog2(DEPTH):0]  fifo_count,
  input seq_state_e              seq_state,
  input logic [GATE_W:0]         seq_t,
  input logic                    seq_hit_late
);
  // R2 / R3: an open gate runs on, counting one step per cycle, until the late point
  p_gate_runs_r2: assert property (@(posedge clk) disable iff (rst)
    (seq_state == S_GATE && !seq_hit_late) |=> (seq_state == S_GATE && seq_t == $past(seq_t) + 1'b1));

  // R6: the second record state only follows an open gate
  p_tail_after_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (seq_state == S_TAIL) |-> ($past(seq_state) == S_GATE));

  // R10: a strobe is always preceded by a record from the sequencer
  p_strobe_has_record_r10: assert property (@(posedge clk) disable iff (rst)
    rec_strobe |-> $past(seq_push));

  // R9: overflow stays set until a register write
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !reg_wr) |=> ovf_flag);

  // R9: a register write empties the FIFO and clears overflow
  p_write_clears_r9: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> (!ovf_flag && fifo_count == '0));

  // R9: occupancy never exceeds capacity
  p_no_overfill_r9: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= ($clog2(DEPTH)+1)'(DEPTH));
endmodule

bind gated_sample_acq gated_sample_acq_chk #(.GATE_W(GATE_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .ovf_flag(ovf_flag), .rec_strobe(rec_strobe),
  .seq_push(seq_push), .fifo_count(fifo_count), .seq_state(u_seq.state_q),
  .seq_t(u_seq.t_q), .seq_hit_late(u_seq.hit_late)
);

// File: tb/gated_sample_acq_tb_top.sv
module gated_sample_acq_tb_top;
  localparam int TRIG_N = 8;
  localparam int ADC_W  = 14;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [TRIG_N-1:0] trig = '0;
  logic [ADC_W-1:0]  adc_v = '0;
  int                adc_step = 1;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              rec_strobe, ovf_flag;

  int checks = 0, errors = 0, strobes = 0;

  always #4 clk = ~clk;

  always @(negedge clk) adc_v <= adc_v + ADC_W'(adc_step);
  always @(negedge clk) if (rec_strobe) strobes++;

  gated_sample_acq dut_i (
    .clk(clk), .rst(rst), .trig_in(trig), .adc_data(adc_v),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rec_strobe(rec_strobe), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = int'(reg_rdata);
  endtask

  // R11: program all parameters; mode in bits 16:14 of address 2
  task automatic setup(input int sel, input int g, input int d, input int l, input int mode);
    wr(3'd0, 32'(sel));
    wr(3'd1, 32'(g));
    wr(3'd2, (32'(mode) << 14) | 32'(d));
    wr(3'd4, 32'(l));
    strobes = 0;
  endtask

  // Raise a line; a0 is the ADC value seen at edge E
  task automatic fire(input int idx, output int a0);
    @(negedge clk); trig[idx] = 1'b1; #1 a0 = int'(adc_v);
    wait_cyc(2); trig[idx] = 1'b0;
  endtask

  function automatic int adc_at(input int a0, input int k);
    return (a0 + adc_step * k) & ((1 << ADC_W) - 1);
  endfunction

  task automatic t_reset;
    int d;
    chk("R1 ovf", int'(ovf_flag), 0);
    chk("R1 strobe", int'(rec_strobe), 0);
    rd(3'd1, d); chk("R1 empty read", d, 0);
    rd(3'd0, d); chk("R1 bus id", d, 5);
  endtask

  task automatic t_diff_up;
    int a0, d;
    adc_v = 14'd100; adc_step = 1;
    setup(0, 20, 18, 18, 0);
    fire(0, a0); wait_cyc(60);
    rd(3'd1, d); chk("R4 R3 diff up", d, 32'h10000 | 20);
    rd(3'd1, d); chk("R8 empty after pop", d, 0);
    chk("R10 one strobe", strobes, 1);
  endtask

  task automatic t_diff_down;
    int a0, d;
    adc_v = 14'd10000; adc_step = -1;
    setup(0, 20, 18, 18, 0);
    fire(0, a0); wait_cyc(60);
    rd(3'd1, d); chk("R4 negative diff", d, 32'h1FFEC);
    adc_step = 1; adc_v = 14'd500;
    setup(0, 5, 2, 3, 6);
    fire(0, a0); wait_cyc(30);
    rd(3'd1, d); chk("R4 code 6 as diff", d, 32'h10000 | 6);
  endtask

  task automatic t_single;
    int a0, d;
    adc_v = 14'd1000; setup(0, 30, 18, 20, 1);
    fire(0, a0); wait_cyc(70);
    rd(3'd1, d); chk("R5 late only", d, 32'h10000 | adc_at(a0, 51));
    chk("R5 late one strobe", strobes, 1);
    setup(0, 30, 18, 20, 2);
    fire(0, a0); wait_cyc(70);
    rd(3'd1, d); chk("R5 early only", d, 32'h10000 | adc_at(a0, 19));
    rd(3'd1, d); chk("R5 early single record", d, 0);
  endtask

  task automatic t_both;
    int a0, d;
    adc_v = 14'd2000; setup(0, 10, 20, 18, 3);
    fire(0, a0); wait_cyc(50);
    chk("R6 two strobes", strobes, 2);
    rd(3'd1, d); chk("R6 early first", d, 32'h10000 | adc_at(a0, 21));
    rd(3'd1, d); chk("R6 late second", d, 32'h10000 | adc_at(a0, 29));
  endtask

  task automatic t_all;
    int a0, d;
    adc_v = 14'd3000; setup(0, 10, 18, 18, 4);
    fire(0, a0); wait_cyc(50);
    chk("R7 record count", strobes, 11);
    for (int k = 19; k <= 29; k++) begin
      rd(3'd1, d); chk("R7 sample in order", d, 32'h10000 | adc_at(a0, k));
    end
    rd(3'd1, d); chk("R7 no extra", d, 0);
  endtask

  task automatic t_retrig;
    int a0, d;
    adc_v = 14'd4000; setup(3, 40, 18, 18, 2);
    fire(1, a0); wait_cyc(80);
    rd(3'd1, d); chk("R2 other line ignored", d, 0);
    fire(3, a0); wait_cyc(4);
    @(negedge clk); trig[3] = 1'b1;          // edge inside open gate
    wait_cyc(100);                           // held high past the end
    chk("R2 retrigger ignored", strobes, 1);
    rd(3'd1, d); chk("R2 record from first edge", d, 32'h10000 | adc_at(a0, 19));
    rd(3'd1, d); chk("R2 held level no new gate", d, 0);
    trig[3] = 1'b0;
    setup(9, 40, 18, 18, 2);
    fire(0, a0); wait_cyc(80);
    rd(3'd1, d); chk("R2 out-of-range select", d, 0);
  endtask

  task automatic t_overflow;
    int a0, d;
    adc_v = 14'd0; setup(0, 600, 0, 0, 4);
    fire(0, a0); wait_cyc(640);
    chk("R10 strobes only for stored", strobes, 512);
    chk("R9 ovf set", int'(ovf_flag), 1);
    rd(3'd1, d); chk("R9 oldest kept", d, 32'h10000 | adc_at(a0, 1));
    chk("R9 ovf sticky", int'(ovf_flag), 1);
    wr(3'd4, 32'd18);
    chk("R9 write clears ovf", int'(ovf_flag), 0);
    rd(3'd1, d); chk("R9 write clears fifo", d, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);
    t_reset();
    t_diff_up();
    t_diff_down();
    t_single();
    t_both();
    t_all();
    t_retrig();
    t_overflow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule